// File: doc/BRIEF.md
# Rate-Adjustable Nanosecond Time Counter

This block keeps a nanosecond time of day for precision time stamping. On every clock edge a numerically controlled oscillator adds a programmable fixed-point increment to a combined register. That register holds a 44-bit nanosecond count and a 28-bit fraction below it. The increment is in nanoseconds with 28 fractional bits. Its reset value of 0x80000000 therefore advances the count by exactly 8 ns per cycle, which is the nominal rate for a 125 MHz clock. Small changes to the increment trim the rate up or down.

Software controls the counter through a simple register port with valid, write, address and data signals. It can stop the count by writing a zero increment, load an absolute time one field at a time, resume counting, and read the time back. The time is split into three fields: a 4-bit low field, a 32-bit middle field and an 8-bit top field. Reading the middle field captures the whole time, so that a later read of the top field agrees with it. The current count is also driven out on `timeNs` for timestamp logic.

Top module: `tod_nco_counter`

## Requirements
- R1: After reset the increment is 0x80000000, the time is zero and the fraction is zero.
- R2: On each edge with no time-field write, the 72-bit value {time, fraction} grows by the increment, taken as nanoseconds with 28 fractional bits; 0x80000000 adds 8 ns.
- R3: The time wraps modulo 2^44 ns with no saturation; 2^44-1 plus 8 ns gives 7.
- R4: With an increment of zero the time holds still. A new increment is used from the edge after the one that writes it.
- R5: Register selection uses address bits [3:2]: 0x0 holds the low field in bits [3:0], 0x4 the middle field (time bits [35:4]), 0x8 the top field (bits [43:36]) read in data bits [7:0], and 0xC the increment. Read data and its valid flag appear one cycle after the read is accepted. Unused read bits are zero, and writes raise no valid flag.
- R6: A write to a time field replaces only that field and leaves the other fields as they were. The increment on that edge is dropped.
- R7: A write to the low field clears the fraction. Writes to the middle or top field keep the fraction.
- R8: A write to the top field takes write data bits [15:8]; all other write bits are ignored. A low-field write uses only data bits [3:0].
- R9: A read of the middle field captures the full 44-bit time. A later read at 0x8 returns the top field of that captured time, even if the live top field has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request, accepted on the edge |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 4 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the read |
| regRdValid | output | 1 | Read data valid pulse |
| timeNs | output | 44 | Current nanosecond count |

## Verification
The assertions assume that the port carries at most one access per cycle and that reads and writes never overlap. They also assume that the increment register changes only through its own address, so a zero increment with no field write must leave the time unchanged. The bench keeps to these assumptions: every access is one valid cycle driven on the falling edge and released on the next one. All time loads and readbacks happen while the increment is zero, so the expected count depends only on how many edges ran with a nonzero increment. The bench counts those edges exactly.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef struct packed {
    logic lowWr;
    logic midWr;
    logic topWr;
    logic incWr;
    logic snapTake;
  } todStrobe_t;

  localparam logic [1:0] SEL_LOW = 2'd0;
  localparam logic [1:0] SEL_MID = 2'd1;
  localparam logic [1:0] SEL_TOP = 2'd2;
  localparam logic [1:0] SEL_INC = 2'd3;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NS_W   = 44,
  parameter int LOW_W  = 4,
  parameter int TOP_W  = 8,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NS_W-1:0]   liveNs,
  input  logic [NS_W-1:0]   snapNs,
  input  logic [INC_W-1:0]  incValue,
  output todStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid
);
  localparam int MID_W = NS_W - LOW_W - TOP_W;

  logic [1:0] sel;
  logic       isWr, isRd;
  logic [DATA_W-1:0] rdNext;

  assign sel  = regAddr[3:2];
  assign isWr = regValid && regWrite;
  assign isRd = regValid && !regWrite;

  always_comb begin
    strobe          = '0;
    strobe.lowWr    = isWr && (sel == SEL_LOW);
    strobe.midWr    = isWr && (sel == SEL_MID);
    strobe.topWr    = isWr && (sel == SEL_TOP);
    strobe.incWr    = isWr && (sel == SEL_INC);
    strobe.snapTake = isRd && (sel == SEL_MID);
  end

  always_comb begin
    unique case (sel)
      SEL_LOW: rdNext = DATA_W'(liveNs[LOW_W-1:0]);
      SEL_MID: rdNext = DATA_W'(liveNs[LOW_W+MID_W-1:LOW_W]);
      SEL_TOP: rdNext = DATA_W'(snapNs[NS_W-1:NS_W-TOP_W]);
      default: rdNext = DATA_W'(incValue);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= isRd;
      if (isRd) regRdata <= rdNext;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.lowWr, strobe.midWr, strobe.topWr, strobe.incWr, strobe.snapTake})); // R5
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> regRdValid); // R5
  AST_WR_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite) |=> !regRdValid); // R5
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NS_W    = 44,
  parameter int LOW_W   = 4,
  parameter int TOP_W   = 8,
  parameter int TOP_LANE = 8,
  parameter int FRAC_W  = 28,
  parameter int INC_W   = 32,
  parameter logic [INC_W-1:0] INC_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [NS_W-1:0]   timeNs,
  output logic [NS_W-1:0]   snapNs,
  output logic [INC_W-1:0]  incValue
);
  localparam int MID_W = NS_W - LOW_W - TOP_W;
  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [INC_W-1:0] incReg;
  logic [FRAC_W-1:0] fracAcc;
  logic anyFieldWr;

  assign timeNs     = acc[ACC_W-1:FRAC_W];
  assign fracAcc    = acc[FRAC_W-1:0];
  assign incValue   = incReg;
  assign anyFieldWr = strobe.lowWr || strobe.midWr || strobe.topWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      incReg <= INC_RST;
      snapNs <= '0;
    end else begin
      if (strobe.incWr)    incReg <= wdata[INC_W-1:0];
      if (strobe.snapTake) snapNs <= acc[ACC_W-1:FRAC_W];
      if (strobe.lowWr)
        acc <= {acc[ACC_W-1:FRAC_W+LOW_W], wdata[LOW_W-1:0], {FRAC_W{1'b0}}};
      else if (strobe.midWr)
        acc <= {acc[ACC_W-1:ACC_W-TOP_W], wdata[MID_W-1:0], acc[FRAC_W+LOW_W-1:0]};
      else if (strobe.topWr)
        acc <= {wdata[TOP_LANE+TOP_W-1:TOP_LANE], acc[ACC_W-TOP_W-1:0]};
      else
        acc <= acc + ACC_W'(incReg);
    end
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (incReg == '0 && !anyFieldWr) |=> $stable(timeNs)); // R4
  AST_LOW_CLEARS_FRAC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lowWr |=> (fracAcc == '0)); // R7
  AST_MID_KEEPS_REST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.midWr |=> (timeNs[LOW_W-1:0] == $past(timeNs[LOW_W-1:0])) &&
                     (timeNs[NS_W-1:NS_W-TOP_W] == $past(timeNs[NS_W-1:NS_W-TOP_W])) &&
                     $stable(fracAcc)); // R6
  AST_TOP_KEEPS_REST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.topWr |=> (timeNs[NS_W-TOP_W-1:0] == $past(timeNs[NS_W-TOP_W-1:0]))); // R6
endmodule

// File: rtl/tod_nco_counter.sv
module tod_nco_counter
  import tod_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NS_W    = 44,
  parameter int LOW_W   = 4,
  parameter int TOP_W   = 8,
  parameter int TOP_LANE = 8,
  parameter int FRAC_W  = 28,
  parameter int INC_W   = 32,
  parameter logic [INC_W-1:0] INC_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRdValid,
  output logic [NS_W-1:0]   timeNs
);
  todStrobe_t        strobe;
  logic [NS_W-1:0]   snapNs;
  logic [INC_W-1:0]  incValue;

  tod_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W),
    .LOW_W(LOW_W), .TOP_W(TOP_W), .INC_W(INC_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .liveNs(timeNs), .snapNs(snapNs), .incValue(incValue),
    .strobe(strobe), .regRdata(regRdata), .regRdValid(regRdValid)
  );

  tod_datapath #(
    .DATA_W(DATA_W), .NS_W(NS_W), .LOW_W(LOW_W), .TOP_W(TOP_W),
    .TOP_LANE(TOP_LANE), .FRAC_W(FRAC_W), .INC_W(INC_W), .INC_RST(INC_RST)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .timeNs(timeNs), .snapNs(snapNs), .incValue(incValue)
  );
endmodule

// File: tb/tb_tod_nco_counter.sv
`timescale 1ns/1ps
module tb_tod_nco_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic [43:0] timeNs;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tod_nco_counter dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .timeNs(timeNs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // entered just after a falling edge, returns just after the next one
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
    check("R5 read valid", 64'(regRdValid), 64'd1);
  endtask

  task automatic readTime(output logic [43:0] t);
    logic [31:0] lo, mi, tp;
    rd(4'h0, lo); rd(4'h4, mi); rd(4'h8, tp);
    check("R5 low upper bits zero", 64'(lo[31:4]), 64'd0);
    check("R5 top upper bits zero", 64'(tp[31:8]), 64'd0);
    t = {tp[7:0], mi, lo[3:0]};
  endtask

  task automatic zeroTime();
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    logic [43:0] t;
    logic [43:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1/R2: two running edges at 8 ns each
    rd(4'hC, d);
    check("R1 increment reset value", 64'(d), 64'h8000_0000);
    wr(4'hC, 32'h0);
    check("R2 nominal 8 ns per edge", 64'(timeNs), 64'd16);
    readTime(t);
    check("R1 R5 field readback", 64'(t), 64'd16);

    // R8: top from bits [15:8]
    wr(4'h8, 32'hFFFF_ABCD);
    readTime(t);
    check("R8 top lane and R6 others kept", 64'(t), {20'd0, 8'hAB, 32'd1, 4'd0});
    wr(4'h0, 32'hFFFF_FFF5);
    check("R8 low uses bits [3:0]", 64'(timeNs), {20'd0, 8'hAB, 32'd1, 4'd5});

    // R9: snapshot coherence
    rd(4'h4, d);
    wr(4'h8, 32'h0000_1200);
    rd(4'h8, d);
    check("R9 top from snapshot", 64'(d), 64'hAB);
    rd(4'h4, d); rd(4'h8, d);
    check("R9 top after new snapshot", 64'(d), 64'h12);

    // R3: wrap
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'h0000_FF00); wr(4'h0, 32'hF);
    wr(4'hC, 32'h8000_0000);
    wr(4'hC, 32'h0);
    check("R3 wrap modulo 2^44", 64'(timeNs), 64'd7);

    // R7/R2: fractional carry
    zeroTime();
    wr(4'hC, 32'h0800_0000);
    repeat (4) @(negedge clk);
    wr(4'hC, 32'h0);
    check("R2 half-ns steps", 64'(timeNs), 64'd2);
    wr(4'h4, 32'h10);
    wr(4'hC, 32'h0800_0000);
    wr(4'hC, 32'h0);
    check("R7 mid write keeps fraction", 64'(timeNs), 64'h103);
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h0800_0000);
    wr(4'hC, 32'h0);
    check("R7 low write clears fraction", 64'(timeNs), 64'h100);

    // R6: increment dropped on field-write edge
    zeroTime();
    wr(4'hC, 32'h8000_0000);
    wr(4'h4, 32'h5);
    wr(4'hC, 32'h0);
    check("R6 field write drops increment", 64'(timeNs), 64'h58);
    check("R5 write raises no read valid", 64'(regRdValid), 64'd0);

    // R2/R4: sweep of increments and run lengths
    for (int i = 0; i < 5; i++) begin
      logic [31:0] inc;
      case (i)
        0: inc = 32'h8000_0000;
        1: inc = 32'h7FFF_FFFF;
        2: inc = 32'hFFFF_FFFF;
        3: inc = 32'h1234_5678;
        default: inc = 32'h0;
      endcase
      for (int k = 0; k < 8; k++) begin
        logic [71:0] prod;
        zeroTime();
        wr(4'hC, inc);
        repeat (k) @(negedge clk);
        wr(4'hC, 32'h0);
        prod = 72'(k + 1) * 72'(inc);
        readTime(t);
        check("R2 R4 sweep point", 64'(t), 64'(prod[71:28]));
      end
    end

    // R4: frozen clock stays put
    held = timeNs;
    wr(4'h4, 32'h3);
    held = {held[43:36], 32'h3, held[3:0]};
    repeat (20) @(negedge clk);
    check("R4 frozen time holds", 64'(timeNs), 64'(held));
    wr(4'hC, 32'h8000_0000);
    repeat (2) @(negedge clk);
    wr(4'hC, 32'h0);
    check("R4 nonzero increment resumes", 64'(timeNs), 64'(held + 44'd24));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule